// File: doc/BRIEF.md
# Downstream Link Bus-State Monitor with Keeper Control

This block sits on the downstream-facing end of a two-wire, strobe-and-data, chip-to-chip USB link. While the link is powered but not enabled, it turns on weak keepers on both wires and holds them at logic zero. Once enabled, it makes the keepers hold the idle levels (strobe high, data low). It then watches the sampled wire levels for a connect from the peripheral.

The wire pair is sampled once per strobe period, on a tick supplied by the surrounding logic. A pattern counts as settled only when it is the same on consecutive ticks. The settled pattern is reported as a two-bit bus-state code. The keeper enable follows that code with one strobe period of lag: it drops one period after a non-idle state is reported and returns one period after idle is reported again. A one-cycle event marks the end of a connect, which is the reported state moving from connect to idle.

Top module: `hsic_bus_monitor`

## Requirements
- R1: While `enable` is low, `keeper_en` is 1, `keeper_level` is 2'b00, `bus_state` is 0 (idle) and `connect_evt` is 0.
- R2: While `enable` is high, `keeper_level` is 2'b10 (bit 1 strobe level high, bit 0 data level low).
- R3: The wires are sampled only in clock cycles where `period_tick` is 1. The pattern {strobe,data} decodes as follows: 2'b10 gives code 0 (idle/suspend), 2'b01 gives code 1 (connect/resume), 2'b00 gives code 2 (reset), and 2'b11 gives code 3 (active data). Wire changes between ticks never change `bus_state`.
- R4: `bus_state` takes a new code only at a tick whose sample equals the sample from the previous tick (HOLD_PERIODS=2 consecutive periods). A pattern seen on a single tick leaves `bus_state` unchanged.
- R5: At each tick, `keeper_en` becomes 1 if `bus_state` was idle just before that tick, and 0 otherwise. The keeper therefore switches off one period after a non-idle state is reported and on again one period after idle is reported.
- R6: `connect_evt` is a one-clock pulse, given in the cycle after the tick at which `bus_state` moves from code 1 to code 0. This holds for any connect pattern held at least 2 periods.
- R7: Other transitions into idle, or out of connect into another state, give no `connect_evt`.
- R8: Dropping `enable` returns all outputs to the R1 values at the next clock edge, and the sampling history is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Link interface enabled |
| strobe_in | input | 1 | Sampled strobe wire level |
| data_in | input | 1 | Sampled data wire level |
| period_tick | input | 1 | One-cycle pulse once per strobe period |
| keeper_en | output | 1 | Weak keepers active on both wires |
| keeper_level | output | 2 | Keeper levels, bit 1 strobe, bit 0 data |
| bus_state | output | 2 | Settled bus-state code |
| connect_evt | output | 1 | One-cycle pulse at the end of a connect |

## Verification
The assertions assume that `period_tick` is a single-cycle pulse. They also assume that the wire levels are steady around each tick, and that enable changes happen away from ticks. The bench honours these assumptions in three ways. It raises each tick for exactly one clock, with idle clocks in between. It changes the wires and `enable` only on falling clock edges between ticks. It checks every tick-driven output on the falling edge that follows the tick's rising edge, so the one-cycle connect pulse is still visible when sampled.

// File: rtl/hsic_bus_monitor.sv
module hsic_bus_monitor #(
  parameter int HOLD_PERIODS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       strobe_in,
  input  logic       data_in,
  input  logic       period_tick,
  output logic       keeper_en,
  output logic [1:0] keeper_level,
  output logic [1:0] bus_state,
  output logic       connect_evt
);
  localparam int RUN_W = (HOLD_PERIODS > 2) ? $clog2(HOLD_PERIODS) : 1;
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(HOLD_PERIODS - 1);
  localparam logic [1:0] ST_IDLE = 2'd0, ST_CONN = 2'd1, ST_RST = 2'd2, ST_ACT = 2'd3;

  logic [1:0]       prev_q, state_q, decoded;
  logic             prev_vld, kp_q, evt_q;
  logic [RUN_W-1:0] run_q, run_nxt;

  wire [1:0] line    = {strobe_in, data_in};
  wire       same    = prev_vld && (line == prev_q);
  wire       settled = (run_nxt == RUN_MAX);

  always_comb begin
    case (line)
      2'b10:   decoded = ST_IDLE;
      2'b01:   decoded = ST_CONN;
      2'b00:   decoded = ST_RST;
      default: decoded = ST_ACT;
    endcase
  end

  assign run_nxt = !same ? '0 : (run_q == RUN_MAX) ? run_q : run_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 2'b00; prev_vld <= 1'b0; run_q <= '0;
      state_q <= ST_IDLE; kp_q <= 1'b1; evt_q <= 1'b0;
    end else if (!enable) begin
      prev_q <= 2'b00; prev_vld <= 1'b0; run_q <= '0;
      state_q <= ST_IDLE; kp_q <= 1'b1; evt_q <= 1'b0;
    end else begin
      evt_q <= 1'b0;
      if (period_tick) begin
        prev_q   <= line;
        prev_vld <= 1'b1;
        run_q    <= run_nxt;
        kp_q     <= (state_q == ST_IDLE);
        if (settled) begin
          state_q <= decoded;
          evt_q   <= (state_q == ST_CONN) && (decoded == ST_IDLE);
        end
      end
    end
  end

  assign keeper_en    = kp_q;
  assign keeper_level = {enable, 1'b0};
  assign bus_state    = state_q;
  assign connect_evt  = evt_q;

  // R3
  state_only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !period_tick) |=> (!enable || $stable(bus_state)));
  // R5
  keeper_only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !period_tick) |=> (!enable || $stable(keeper_en)));
  // R6
  evt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    connect_evt |=> !connect_evt);
  // R6
  evt_from_connect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    connect_evt |-> (bus_state == ST_IDLE && $past(bus_state) == ST_CONN));
  // R8
  disabled_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!enable |-> (keeper_en && bus_state == ST_IDLE && !connect_evt)));
  // R2
  level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable |-> keeper_level == 2'b10);
endmodule

// File: tb/tb_hsic_bus_monitor.sv
module tb_hsic_bus_monitor;
  logic clk = 0, rst_n = 0, enable = 0, strobe_in = 0, data_in = 0, period_tick = 0;
  logic keeper_en, connect_evt;
  logic [1:0] keeper_level, bus_state;
  int errors = 0, checks = 0;

  hsic_bus_monitor dut (.clk(clk), .rst_n(rst_n), .enable(enable), .strobe_in(strobe_in),
    .data_in(data_in), .period_tick(period_tick), .keeper_en(keeper_en),
    .keeper_level(keeper_level), .bus_state(bus_state), .connect_evt(connect_evt));

  always #2.5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    repeat (2) @(negedge clk);
    period_tick = 1;
    @(negedge clk);
    period_tick = 0;
  endtask

  task automatic lines(logic [1:0] p);
    {strobe_in, data_in} = p;
  endtask

  task automatic t_disabled();
    chk("R1 keeper_en", keeper_en, 1);
    chk("R1 level", keeper_level, 0);
    chk("R1 state", bus_state, 0);
    chk("R1 evt", connect_evt, 0);
  endtask

  task automatic t_enable_idle();
    @(negedge clk); enable = 1; lines(2'b10);
    @(negedge clk);
    chk("R2 level", keeper_level, 2);
    repeat (3) tick();
    chk("R3 idle code", bus_state, 0);
    chk("R5 keeper on idle", keeper_en, 1);
  endtask

  task automatic t_connect();
    lines(2'b01); tick();
    chk("R4 single-tick connect ignored", bus_state, 0);
    tick();
    chk("R3 connect code", bus_state, 1);
    chk("R5 keeper still on", keeper_en, 1);
    tick();
    chk("R5 keeper off one period later", keeper_en, 0);
    lines(2'b10); tick();
    chk("R4 idle not yet settled", bus_state, 1);
    chk("R6 no early evt", connect_evt, 0);
    tick();
    chk("R6 connect evt", connect_evt, 1);
    chk("R6 state idle", bus_state, 0);
    chk("R5 keeper still off", keeper_en, 0);
    @(negedge clk);
    chk("R6 evt one cycle", connect_evt, 0);
    tick();
    chk("R5 keeper back on", keeper_en, 1);
  endtask

  task automatic t_glitch();
    lines(2'b00); tick();
    lines(2'b10); tick();
    chk("R4 glitch state", bus_state, 0);
    chk("R4 glitch keeper", keeper_en, 1);
    tick();
  endtask

  task automatic t_no_tick();
    lines(2'b00);
    repeat (12) @(negedge clk);
    chk("R3 no tick no change", bus_state, 0);
    lines(2'b10);
    repeat (2) tick();
  endtask

  task automatic t_reset_and_others();
    int seen = 0;
    lines(2'b00); repeat (2) tick();
    chk("R3 reset code", bus_state, 2);
    lines(2'b11); repeat (2) tick();
    chk("R3 active code", bus_state, 3);
    lines(2'b01); tick(); tick(); seen += connect_evt;
    chk("R3 connect again", bus_state, 1);
    lines(2'b00); tick(); seen += connect_evt; tick(); seen += connect_evt;
    chk("R7 connect to reset", bus_state, 2);
    lines(2'b10); tick(); seen += connect_evt; tick(); seen += connect_evt;
    chk("R7 reset to idle state", bus_state, 0);
    chk("R7 no evt", seen, 0);
    tick();
  endtask

  task automatic t_resume();
    lines(2'b01); repeat (4) tick();
    chk("R6 long resume state", bus_state, 1);
    lines(2'b10); tick(); tick();
    chk("R6 evt after long hold", connect_evt, 1);
  endtask

  task automatic t_disable();
    lines(2'b00); repeat (2) tick(); tick();
    chk("R5 keeper off in reset", keeper_en, 0);
    enable = 0;
    @(negedge clk);
    chk("R8 keeper", keeper_en, 1);
    chk("R8 level", keeper_level, 0);
    chk("R8 state", bus_state, 0);
    tick();
    chk("R8 state held while disabled", bus_state, 0);
  endtask

  initial begin
    #200us;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_disabled();
    t_enable_idle();
    t_connect();
    t_glitch();
    t_no_tick();
    t_reset_and_others();
    t_resume();
    t_disable();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule